// File: doc/BRIEF.md
# Long multiply-accumulate unit

This unit forms the full 64-bit product of two 32-bit operands for a processor datapath. A 2-bit operation code chooses unsigned or two's complement arithmetic, and chooses whether the product stands alone or is added to a 64-bit accumulator. The accumulator arrives as a low half and a high half. The result leaves as a low word and a high word, each with its own write enable, so that the register file can write both destinations on the same cycle.

The multiply is iterative and takes one 8-bit digit of the second operand per cycle. A result is ready four clock edges after the edge that accepts the start request. The caller supplies a condition-pass bit and a flag-update request with the operands. If the condition fails, the unit still runs and still signals done, but it raises no write enable and leaves the flags alone. If flags are requested, N and Z follow the 64-bit result. A build parameter selects how C and V behave: in the current behaviour they keep their incoming values, and in the legacy behaviour they are forced to zero.

Top module: `lmac_unit`

## Requirements
- R1: `op_i[0]` = 1 selects accumulate and `op_i[1]` = 1 selects signed. The codes are 00 unsigned multiply, 01 unsigned multiply-accumulate, 10 signed multiply and 11 signed multiply-accumulate. With `op_i[1]` = 0, both operands are read as unsigned 32-bit integers.
- R2: With `op_i[1]` = 1, both operands are read as 32-bit two's complement integers, and the 64-bit result is the two's complement product.
- R3: Bits 31:0 of the 64-bit result appear on `res_lo_o`, and bits 63:32 appear on `res_hi_o`.
- R4: In the accumulate codes, the result is the product plus `{acc_hi_i, acc_lo_i}` (high half as bits 63:32), taken modulo 2^64.
- R5: When the condition passes and `set_flags_i` is 1, N (`flags_o[3]`) equals result bit 63, and Z (`flags_o[2]`) is 1 exactly when all 64 result bits are zero.
- R6: On a flag update, C (`flags_o[1]`) and V (`flags_o[0]`) equal the incoming `flags_i[1:0]` when `LEGACY_CV` = 0, and are both 0 when `LEGACY_CV` = 1.
- R7: When `set_flags_i` is 0, `flags_o` equals `flags_i` as captured at start.
- R8: When `cond_pass_i` is 0 at start, `wr_lo_o` and `wr_hi_o` stay 0, `flags_o` equals the captured `flags_i`, and `done_o` is still raised.
- R9: `done_o` is a one-cycle pulse that goes high after the fourth rising edge following the edge that accepts `start_i`. `wr_lo_o` and `wr_hi_o` are high only in that cycle, and both are high when the condition passed.
- R10: A `start_i` that arrives while an operation is in progress is ignored. It does not change that operation's result and does not produce a second done pulse.
- R11: After reset, `done_o`, both write enables, both result words and `flags_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a new operation; sampled only when idle |
| op_i | input | 2 | Operation code: bit 1 selects signed, bit 0 selects accumulate |
| cond_pass_i | input | 1 | Condition result for this operation |
| set_flags_i | input | 1 | Request a flag update |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand |
| acc_lo_i | input | 32 | Accumulator bits 31:0 |
| acc_hi_i | input | 32 | Accumulator bits 63:32 |
| flags_i | input | 4 | Current flags, ordered {N, Z, C, V} |
| res_lo_o | output | 32 | Result bits 31:0 |
| res_hi_o | output | 32 | Result bits 63:32 |
| wr_lo_o | output | 1 | Write enable for the low result word |
| wr_hi_o | output | 1 | Write enable for the high result word |
| flags_o | output | 4 | Flags after the operation, ordered {N, Z, C, V} |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The operands, the condition bit, the flag request and the incoming flags are all captured on the edge that accepts start. The results, the write enables and the flags are due in the cycle after the fourth edge that follows. The bench samples on falling edges. After each of the first three edges it confirms that done is still low. After the fourth it confirms done and reads all outputs, comparing them with a 64-bit arithmetic model evaluated in the bench, or with hand-derived constants for the named corner cases. A second instance built with the legacy C/V behaviour receives the same stimulus and has its flags checked in the same cycle.

// File: rtl/lmac_pkg.sv
// Shared definitions for the long multiply-accumulate unit.
// Assumes a 2-bit operation code whose upper bit selects signed and lower bit selects accumulate.
package lmac_pkg;

    typedef enum logic [1:0] {
        OP_UMUL = 2'b00,
        OP_UMAC = 2'b01,
        OP_SMUL = 2'b10,
        OP_SMAC = 2'b11
    } lmac_op_e;

    // Bit positions inside the 4-bit flag vector {N, Z, C, V}
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    function automatic logic op_is_signed(lmac_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_accum(lmac_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/lmac_ctrl.sv
// Sequencer: accepts a start request when idle, enables STEPS datapath
// steps, then raises a one-cycle done strobe.
// Assumes start is ignored while busy; done coincides with the last step edge.
module lmac_ctrl #(
    parameter int STEPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(STEPS + 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    // Accept only when no operation is in flight
    assign accept_o = start_i & ~busy_q;
    assign step_o   = busy_q;
    assign busy_o   = busy_q;
    assign done_o   = done_q;

    // Step counter, busy state and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(STEPS - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lmac_datapath.sv
// Iterative multiplier and accumulator. On load it sign- or zero-extends the
// multiplicand and seeds the sum with the accumulator, minus the correction for
// a negative signed multiplier. Each step then adds one DIGIT_W-bit digit
// partial product. All arithmetic wraps modulo 2^(2*XLEN).
// Assumes XLEN is a multiple of DIGIT_W.
module lmac_datapath #(
    parameter int XLEN    = 32,
    parameter int DIGIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              signed_i,
    input  logic              accum_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    input  logic [XLEN-1:0]   acc_lo_i,
    input  logic [XLEN-1:0]   acc_hi_i,
    output logic [2*XLEN-1:0] sum_o
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0]   mcand_q;
    logic [XLEN-1:0] mplier_q;
    logic [PW-1:0]   sum_q;

    logic [PW-1:0]   a_ext;
    logic [PW-1:0]   seed;
    logic [PW-1:0]   fix;
    logic [PW-1:0]   partial;

    // Extend the operand and build the starting sum
    always_comb begin
        a_ext = signed_i ? {{XLEN{a_i[XLEN-1]}}, a_i} : {{XLEN{1'b0}}, a_i};
        fix   = (signed_i && b_i[XLEN-1]) ? {a_i, {XLEN{1'b0}}} : '0;
        seed  = (accum_i ? {acc_hi_i, acc_lo_i} : '0) - fix;
    end

    // Partial product of the current low digit
    assign partial = mcand_q * {{(PW-DIGIT_W){1'b0}}, mplier_q[DIGIT_W-1:0]};

    // Load the operands, then shift-and-add one digit per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            sum_q    <= '0;
        end else if (load_i) begin
            mcand_q  <= a_ext;
            mplier_q <= b_i;
            sum_q    <= seed;
        end else if (step_i) begin
            sum_q    <= sum_q + partial;
            mcand_q  <= mcand_q << DIGIT_W;
            mplier_q <= mplier_q >> DIGIT_W;
        end
    end

    assign sum_o = sum_q;

endmodule

// File: rtl/lmac_flags.sv
// Flag update logic. N and Z follow the 64-bit result when an update is
// requested and the condition passed. C and V either pass through or are
// forced to zero, chosen by LEGACY_CV.
// Assumes the flag vector is ordered {N, Z, C, V}.
module lmac_flags #(
    parameter int PW        = 64,
    parameter bit LEGACY_CV = 1'b0
) (
    input  logic [3:0]    flags_i,
    input  logic          set_i,
    input  logic          pass_i,
    input  logic [PW-1:0] result_i,
    output logic [3:0]    flags_o
);
    import lmac_pkg::*;

    logic [1:0] cv_upd;

    // Variant chosen by parameter: legacy clears C/V, current keeps them
    generate
        if (LEGACY_CV) begin : g_cv_clear
            assign cv_upd = 2'b00;
        end else begin : g_cv_keep
            assign cv_upd = {flags_i[FLG_C], flags_i[FLG_V]};
        end
    endgenerate

    // Choose the updated or unchanged flag vector
    always_comb begin
        flags_o = flags_i;
        if (set_i && pass_i) begin
            flags_o[FLG_N] = result_i[PW-1];
            flags_o[FLG_Z] = (result_i == '0);
            flags_o[FLG_C] = cv_upd[1];
            flags_o[FLG_V] = cv_upd[0];
        end
    end

endmodule

// File: rtl/lmac_unit.sv
// Long multiply-accumulate unit: 32x32 to 64-bit product, signed or unsigned,
// with optional 64-bit accumulate and N/Z/C/V flag update.
// Assumes inputs are stable only on the start cycle; every input that matters
// later is captured when start is accepted. Results hold until the next start.
module lmac_unit #(
    parameter int XLEN      = 32,
    parameter int DIGIT_W   = 8,
    parameter bit LEGACY_CV = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic            cond_pass_i,
    input  logic            set_flags_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    input  logic [XLEN-1:0] acc_lo_i,
    input  logic [XLEN-1:0] acc_hi_i,
    input  logic [3:0]      flags_i,
    output logic [XLEN-1:0] res_lo_o,
    output logic [XLEN-1:0] res_hi_o,
    output logic            wr_lo_o,
    output logic            wr_hi_o,
    output logic [3:0]      flags_o,
    output logic            done_o
);
    import lmac_pkg::*;

    localparam int PW    = 2 * XLEN;
    localparam int STEPS = XLEN / DIGIT_W;

    logic          accept;
    logic          step;
    logic          busy;
    logic          done;
    logic [PW-1:0] sum;
    lmac_op_e      op;

    logic          cond_q;
    logic          setf_q;
    logic [3:0]    flags_q;

    assign op = lmac_op_e'(op_i);

    lmac_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .step_o   (step),
        .busy_o   (busy),
        .done_o   (done)
    );

    lmac_datapath #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .step_i   (step),
        .signed_i (op_is_signed(op)),
        .accum_i  (op_is_accum(op)),
        .a_i      (src_a_i),
        .b_i      (src_b_i),
        .acc_lo_i (acc_lo_i),
        .acc_hi_i (acc_hi_i),
        .sum_o    (sum)
    );

    // Capture the per-operation control inputs on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q  <= 1'b0;
            setf_q  <= 1'b0;
            flags_q <= 4'b0000;
        end else if (accept) begin
            cond_q  <= cond_pass_i;
            setf_q  <= set_flags_i;
            flags_q <= flags_i;
        end
    end

    lmac_flags #(.PW(PW), .LEGACY_CV(LEGACY_CV)) u_flags (
        .flags_i  (flags_q),
        .set_i    (setf_q),
        .pass_i   (cond_q),
        .result_i (sum),
        .flags_o  (flags_o)
    );

    assign res_lo_o = sum[XLEN-1:0];
    assign res_hi_o = sum[PW-1:XLEN];
    assign wr_lo_o  = done & cond_q;
    assign wr_hi_o  = done & cond_q;
    assign done_o   = done;

endmodule

// File: rtl/lmac_checker.sv
// Property checker for lmac_unit, attached by bind. It keeps its own copy of
// the per-operation inputs, captured whenever the unit accepts a start.
module lmac_checker #(
    parameter int XLEN      = 32,
    parameter bit LEGACY_CV = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy,
    input logic            cond_pass_i,
    input logic            set_flags_i,
    input logic [3:0]      flags_i,
    input logic [XLEN-1:0] res_lo_o,
    input logic [XLEN-1:0] res_hi_o,
    input logic            wr_lo_o,
    input logic            wr_hi_o,
    input logic [3:0]      flags_o,
    input logic            done_o
);
    logic       cond_cap;
    logic       setf_cap;
    logic [3:0] flags_cap;

    // Shadow capture of the inputs that qualify the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_cap  <= 1'b0;
            setf_cap  <= 1'b0;
            flags_cap <= 4'b0000;
        end else if (start_i && !busy) begin
            cond_cap  <= cond_pass_i;
            setf_cap  <= set_flags_i;
            flags_cap <= flags_i;
        end
    end

    // R9: write enables only with done
    a_r9_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_o || wr_hi_o) |-> done_o);

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: done follows a busy period
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    // R8: failed condition blocks writes and flag changes
    a_r8_cond_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cond_cap) |-> (!wr_lo_o && !wr_hi_o && flags_o == flags_cap));

    // R7: no flag request leaves flags untouched
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !setf_cap) |-> (flags_o == flags_cap));

    // R5: N and Z follow the result
    a_r5_nz_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cond_cap && setf_cap) |->
        (flags_o[3] == res_hi_o[XLEN-1] && flags_o[2] == ({res_hi_o, res_lo_o} == '0)));

    // R6: C and V per the selected behaviour
    a_r6_cv_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cond_cap && setf_cap) |->
        (flags_o[1:0] == (LEGACY_CV ? 2'b00 : flags_cap[1:0])));

endmodule

bind lmac_unit lmac_checker #(.XLEN(XLEN), .LEGACY_CV(LEGACY_CV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy        (busy),
    .cond_pass_i (cond_pass_i),
    .set_flags_i (set_flags_i),
    .flags_i     (flags_i),
    .res_lo_o    (res_lo_o),
    .res_hi_o    (res_hi_o),
    .wr_lo_o     (wr_lo_o),
    .wr_hi_o     (wr_hi_o),
    .flags_o     (flags_o),
    .done_o      (done_o)
);

// File: tb/sim_lmac_unit.sv
// Self-checking bench: sweeps every operation code over a grid of corner
// operands, then runs named corner cases and a busy-start case.
module sim_lmac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        cond = 1'b1;
    logic        setf = 1'b0;
    logic [31:0] a = '0, b = '0, alo = '0, ahi = '0;
    logic [3:0]  fin = '0;

    logic [31:0] lo0, hi0, lo1, hi1;
    logic        wl0, wh0, wl1, wh1, dn0, dn1;
    logic [3:0]  fo0, fo1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lmac_unit #(.LEGACY_CV(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .cond_pass_i(cond), .set_flags_i(setf), .src_a_i(a), .src_b_i(b),
        .acc_lo_i(alo), .acc_hi_i(ahi), .flags_i(fin),
        .res_lo_o(lo0), .res_hi_o(hi0), .wr_lo_o(wl0), .wr_hi_o(wh0),
        .flags_o(fo0), .done_o(dn0)
    );

    lmac_unit #(.LEGACY_CV(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .cond_pass_i(cond), .set_flags_i(setf), .src_a_i(a), .src_b_i(b),
        .acc_lo_i(alo), .acc_hi_i(ahi), .flags_i(fin),
        .res_lo_o(lo1), .res_hi_o(hi1), .wr_lo_o(wl1), .wr_hi_o(wh1),
        .flags_o(fo1), .done_o(dn1)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // 64-bit arithmetic model of the requirements (R1, R2, R4)
    function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] x,
                                          input logic [31:0] y, input logic [31:0] l,
                                          input logic [31:0] h);
        logic [63:0] xe, ye, p;
        xe = o[1] ? {{32{x[31]}}, x} : {32'b0, x};
        ye = o[1] ? {{32{y[31]}}, y} : {32'b0, y};
        p  = xe * ye;
        if (o[0]) p = p + {h, l};
        return p;
    endfunction

    // Expected flags from R5..R8
    function automatic logic [3:0] eflags(input logic [63:0] r, input logic [3:0] f,
                                          input logic c, input logic s, input bit legacy);
        if (!(c && s)) return f;
        return {r[63], r == 64'd0, legacy ? 2'b00 : f[1:0]};
    endfunction

    // Issue one operation and check everything on its done cycle
    task automatic run_op(input string tag, input logic [1:0] o, input logic [31:0] x,
                          input logic [31:0] y, input logic [31:0] l, input logic [31:0] h,
                          input logic c, input logic s, input logic [3:0] f,
                          input logic [63:0] exp);
        bit early;
        @(negedge clk);
        op = o; a = x; b = y; alo = l; ahi = h; cond = c; setf = s; fin = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (dn0) early = 1'b1;
        end
        chk("R9", {tag, " done early"}, {63'd0, early}, 64'd0);
        @(negedge clk);
        chk("R9", {tag, " done on 4th edge"}, {63'd0, dn0}, 64'd1);
        chk("R3", {tag, " low word"}, {32'd0, lo0}, {32'd0, exp[31:0]});
        chk("R3", {tag, " high word"}, {32'd0, hi0}, {32'd0, exp[63:32]});
        chk("R8", {tag, " write enables"}, {62'd0, wl0, wh0}, c ? 64'd3 : 64'd0);
        chk("R5", {tag, " flags"}, {60'd0, fo0}, {60'd0, eflags(exp, f, c, s, 1'b0)});
        chk("R6", {tag, " legacy flags"}, {60'd0, fo1}, {60'd0, eflags(exp, f, c, s, 1'b1)});
    endtask

    initial begin
        logic [31:0] vals [8];
        vals = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF, 32'h8000_0000,
                 32'hFFFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "done", {63'd0, dn0}, 64'd0);
        chk("R11", "write enables", {62'd0, wl0, wh0}, 64'd0);
        chk("R11", "result", {hi0, lo0}, 64'd0);
        chk("R11", "flags", {60'd0, fo0}, 64'd0);

        // Sweep: R1 unsigned, R2 signed, R4 accumulate, R7/R8 flag and condition mixes
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic c, s;
                    logic [3:0] f;
                    c = ((i + j) % 5) != 0;
                    s = (j % 2) == 0;
                    f = 4'((i * 3 + j + o) & 15);
                    run_op(o[1] ? (o[0] ? "R2/R4 smac" : "R2 smul") : (o[0] ? "R1/R4 umac" : "R1 umul"),
                           o[1:0], vals[i], vals[j], vals[(i + j) % 8], vals[(i * 5 + j) % 8],
                           c, s, f,
                           model(o[1:0], vals[i], vals[j], vals[(i + j) % 8], vals[(i * 5 + j) % 8]));
                end
            end
        end

        // Named corner cases with hand-derived results
        run_op("R2 most-negative squared", 2'b10, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0,
               1'b1, 1'b1, 4'b1111, 64'h4000_0000_0000_0000);
        run_op("R2 minus-one squared", 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0,
               1'b1, 1'b1, 4'b0010, 64'h0000_0000_0000_0001);
        run_op("R1 all-ones squared", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0,
               1'b1, 1'b1, 4'b0001, 64'hFFFF_FFFE_0000_0001);
        run_op("R4 unsigned wrap to zero", 2'b01, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
               1'b1, 1'b1, 4'b0011, 64'h0);
        run_op("R4 signed wrap to negative", 2'b11, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
               1'b1, 1'b1, 4'b0000, 64'h8000_0000_0000_0000);
        run_op("R4 signed negative product", 2'b11, 32'hFFFF_FFFE, 32'h3, 32'h5, 32'h0,
               1'b1, 1'b0, 4'b1010, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R8 condition fails", 2'b00, 32'h10, 32'h10, 32'h0, 32'h0,
               1'b0, 1'b1, 4'b0110, 64'h100);

        // R10: a start during busy is ignored
        begin
            int extra;
            @(negedge clk);
            op = 2'b00; a = 32'd7; b = 32'd9; cond = 1'b1; setf = 1'b0; fin = 4'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            a = 32'd100; b = 32'd100; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            chk("R10", "first done on time", {63'd0, dn0}, 64'd1);
            chk("R10", "result kept", {hi0, lo0}, 64'd63);
            extra = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (dn0) extra++;
            end
            chk("R10", "no second done", 64'(extra), 64'd0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule